// File: doc/BRIEF.md
# CSI-2 Receiver Bring-Up Sequencer

This block is the control state machine that takes a camera serial receiver and its D-PHY from reset to a streaming link, and back down again. On the first stream-on request it raises a one-cycle strobe that asks a separate PHY test-port writer to program the frequency range for the chosen line rate. It then loads the lane-count code and releases the PHY shutdown, the PHY reset and the controller reset, one per cycle. After that it waits for LP-11 stop state on the clock lane and on every active data lane. It then turns on the sensor stream, waits for the sensor's acknowledge and finally waits for the high-speed receive clock.

Every wait is bounded by a shared cycle timer whose length is a parameter (500 ms worth of cycles by default). A stop-state timeout only sets a sticky warning and bring-up carries on. An acknowledge or clock timeout is fatal: the sensor enable drops first, then all three resets fall together and a sticky error is raised. A reference count of stream users makes sure that only the first stream-on starts the hardware and only the last stream-off stops it.

The state sequence is IDLE, FREQ, LANES, REL_SHUT, REL_PHY, REL_CTRL, WAIT_STOP, SENSOR_ON, WAIT_CLK and UP. Teardown runs DOWN_SENSOR, then DOWN_RESET, then back to IDLE. The transitions are as follows:
- IDLE to FREQ on an accepted start.
- FREQ through REL_CTRL advance unconditionally.
- WAIT_STOP to SENSOR_ON when the stop mask is met or on timeout.
- SENSOR_ON to WAIT_CLK on acknowledge.
- WAIT_CLK to UP on the HS clock.
- SENSOR_ON or WAIT_CLK to DOWN_SENSOR on timeout.
- UP to DOWN_SENSOR on the last stream-off.

Top module: `csi_bringup_seq`

## Requirements
- R1: After reset, phy_shutdown_n, phy_rst_n, ctrl_rst_n, sensor_en, freq_prog_req, link_up and busy are all 0, and lane_code is 0.
- R2: An accepted start gives freq_prog_req high for exactly one cycle, the cycle after the request, while all three resets are still asserted. During that cycle freq_mbps equals rate_mbps when rate_valid was high at the request, and 849 otherwise.
- R3: In the cycle after the frequency strobe, lane_code equals cfg_lanes minus one (1..4 lanes give 0..3). A value of 0 is treated as 1 lane and a value above MAX_LANES is treated as MAX_LANES. phy_shutdown_n is still 0 in that cycle.
- R4: The resets are released in three consecutive cycles, in this order: phy_shutdown_n, then phy_rst_n, then ctrl_rst_n.
- R5: The stop-state condition requires phy_state bit 10 and bits 4 to 4+n-1 for n active lanes, and no other bits. Once the condition holds, sensor_en rises one cycle after the wait starts, and link_up follows two cycles later when the acknowledge and the clock are already present.
- R6: If the stop-state condition is not met within TMO_CYCLES, stop_warn is set and bring-up continues, reaching link_up TMO_CYCLES+2 cycles after the wait begins.
- R7: With sensor_en high, the block waits for sensor_ack and then for phy_state bit 8. link_up rises only after bit 8 was seen, and link_up implies sensor_en.
- R8: If sensor_ack or phy_state bit 8 is not seen within TMO_CYCLES, sensor_en drops while the resets are still released. In the next cycle all three resets assert together and link_err is set. The stream count returns to zero, so a single later stream-on starts a fresh bring-up.
- R9: A stream-on starts the hardware only when the count goes from 0 to 1, and a stream-off stops it only when the count goes from 1 to 0. Other accepted requests only change the count, and a stream-off at zero count has no effect.
- R10: Teardown drops sensor_en one cycle before all three resets assert together, and busy returns to 0 one cycle after that.
- R11: busy is 1 from the frequency strobe through the stop-state and clock waits and during teardown. Stream requests made while busy is 1 are ignored.
- R12: A stream-on and a stream-off in the same cycle cancel and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lanes | input | 3 | Number of active data lanes (1..MAX_LANES) |
| rate_valid | input | 1 | rate_mbps holds a supplied line rate |
| rate_mbps | input | 12 | Per-lane line rate in Mbps |
| stream_on_req | input | 1 | One-cycle stream-on request |
| stream_off_req | input | 1 | One-cycle stream-off request |
| phy_state | input | 16 | PHY lane-state word (bit 10 clock stop, bit 8 HS clock active, bits 4.. data stop) |
| sensor_ack | input | 1 | Sensor reports that its stream is running |
| lane_code | output | 2 | Lane-count register value (lanes minus one) |
| phy_shutdown_n | output | 1 | Active-low PHY shutdown |
| phy_rst_n | output | 1 | Active-low PHY reset |
| ctrl_rst_n | output | 1 | Active-low controller reset |
| freq_prog_req | output | 1 | One-cycle request to program the PHY frequency range |
| freq_mbps | output | 12 | Line rate used for the frequency-range choice |
| sensor_en | output | 1 | Sensor stream enable |
| link_up | output | 1 | Bring-up complete, streaming |
| stop_warn | output | 1 | Sticky: stop-state wait timed out |
| link_err | output | 1 | Sticky: fatal acknowledge or clock timeout |
| busy | output | 1 | Sequence in progress; requests ignored |

## Verification
The hardest situations to reach are the timeout paths. Each needs a PHY or sensor input held inactive for a full timer window, and the fatal path must then unwind with exact ordering. The bench builds the block with a 20-cycle timeout and holds the HS clock bit low or sensor_ack low through whole bring-ups. It checks the cycle of the sensor drop against the reset assertion, then confirms that a single new stream-on restarts the sequence. Random lane counts and random PHY words, some with the stop mask forced on, cover the mask decoding, including bits that must be ignored.

// File: rtl/csi_seq_pkg.sv
package csi_seq_pkg;

    // Bit positions in the PHY lane-state word
    localparam int PHY_W         = 16;
    localparam int DATA_STOP_LSB = 4;
    localparam int CLK_HS_BIT    = 8;
    localparam int CLK_STOP_BIT  = 10;

    // Line rate assumed when none is supplied
    localparam int DEFAULT_MBPS  = 849;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FREQ,
        S_LANES,
        S_REL_SHUT,
        S_REL_PHY,
        S_REL_CTRL,
        S_WAIT_STOP,
        S_SENSOR_ON,
        S_WAIT_CLK,
        S_UP,
        S_DOWN_SENSOR,
        S_DOWN_RESET
    } seq_state_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

    // R6: the wait counter never runs past the window
    p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/stream_refcnt.sv
module stream_refcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R9: the request gating never lets the count drop below zero
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

    // R9: the count never wraps past its maximum
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt_q != '1));

endmodule

// File: rtl/lane_stop_check.sv
module lane_stop_check
    import csi_seq_pkg::*;
#(
    parameter int MAX_LANES = 4,
    parameter int LANE_W    = 2
) (
    input  logic [LANE_W-1:0] lane_code,
    input  logic [PHY_W-1:0]  phy_word,
    output logic              stop_met
);
    logic [MAX_LANES-1:0] lane_ok;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        // a lane beyond the active count does not need to be stopped
        assign lane_ok[i] = phy_word[DATA_STOP_LSB + i] || (LANE_W'(i) > lane_code);
    end

    assign stop_met = phy_word[CLK_STOP_BIT] && (&lane_ok);

endmodule

// File: rtl/csi_bringup_seq.sv
module csi_bringup_seq
    import csi_seq_pkg::*;
#(
    parameter int          MAX_LANES  = 4,
    parameter int          RATE_W     = 12,
    parameter int          CNT_W      = 4,
    parameter int unsigned TMO_CYCLES = 100_000_000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(MAX_LANES+1)-1:0] cfg_lanes,
    input  logic                           rate_valid,
    input  logic [RATE_W-1:0]              rate_mbps,
    input  logic                           stream_on_req,
    input  logic                           stream_off_req,
    input  logic [PHY_W-1:0]               phy_state,
    input  logic                           sensor_ack,
    output logic [$clog2(MAX_LANES)-1:0]   lane_code,
    output logic                           phy_shutdown_n,
    output logic                           phy_rst_n,
    output logic                           ctrl_rst_n,
    output logic                           freq_prog_req,
    output logic [RATE_W-1:0]              freq_mbps,
    output logic                           sensor_en,
    output logic                           link_up,
    output logic                           stop_warn,
    output logic                           link_err,
    output logic                           busy
);
    localparam int LANE_CFG_W = $clog2(MAX_LANES + 1);
    localparam int LANE_W     = $clog2(MAX_LANES);
    localparam logic [RATE_W-1:0]     DEF_RATE  = RATE_W'(DEFAULT_MBPS);
    localparam logic [LANE_CFG_W-1:0] LANES_CAP = LANE_CFG_W'(MAX_LANES);

    seq_state_e state_q, state_d;

    logic [CNT_W-1:0]  users;
    logic              on_ok, off_ok, start_go, stop_go, fatal;
    logic              tmo_exp, stop_met;
    logic [LANE_W-1:0] lane_q, lane_clamped;
    logic [RATE_W-1:0] rate_q;
    logic              warn_q, err_q;

    // ---------------- request gating and reference count ----------------
    assign on_ok    = stream_on_req && !stream_off_req && !busy && (users != '1);
    assign off_ok   = stream_off_req && !stream_on_req && !busy && (users != '0);
    assign start_go = on_ok && (users == '0);
    assign stop_go  = off_ok && (users == CNT_W'(1));

    stream_refcnt #(.CNT_W(CNT_W)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (on_ok),
        .dec   (off_ok),
        .clr   (fatal),
        .cnt   (users)
    );

    seq_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .expired (tmo_exp)
    );

    lane_stop_check #(.MAX_LANES(MAX_LANES), .LANE_W(LANE_W)) u_stop (
        .lane_code (lane_q),
        .phy_word  (phy_state),
        .stop_met  (stop_met)
    );

    always_comb begin
        if (cfg_lanes == '0) begin
            lane_clamped = '0;
        end else if (cfg_lanes > LANES_CAP) begin
            lane_clamped = LANE_W'(MAX_LANES - 1);
        end else begin
            lane_clamped = LANE_W'(cfg_lanes - 1'b1);
        end
    end

    assign fatal = tmo_exp &&
                   (((state_q == S_SENSOR_ON) && !sensor_ack) ||
                    ((state_q == S_WAIT_CLK) && !phy_state[CLK_HS_BIT]));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:        if (start_go) state_d = S_FREQ;
            S_FREQ:        state_d = S_LANES;
            S_LANES:       state_d = S_REL_SHUT;
            S_REL_SHUT:    state_d = S_REL_PHY;
            S_REL_PHY:     state_d = S_REL_CTRL;
            S_REL_CTRL:    state_d = S_WAIT_STOP;
            S_WAIT_STOP:   if (stop_met || tmo_exp) state_d = S_SENSOR_ON;
            S_SENSOR_ON: begin
                if (sensor_ack)   state_d = S_WAIT_CLK;
                else if (tmo_exp) state_d = S_DOWN_SENSOR;
            end
            S_WAIT_CLK: begin
                if (phy_state[CLK_HS_BIT]) state_d = S_UP;
                else if (tmo_exp)          state_d = S_DOWN_SENSOR;
            end
            S_UP:          if (stop_go) state_d = S_DOWN_SENSOR;
            S_DOWN_SENSOR: state_d = S_DOWN_RESET;
            S_DOWN_RESET:  state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // ---------------- captured values and sticky flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            rate_q <= '0;
            warn_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start_go) begin
                rate_q <= rate_valid ? rate_mbps : DEF_RATE;
                warn_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (state_q == S_FREQ) lane_q <= lane_clamped;
            if ((state_q == S_WAIT_STOP) && !stop_met && tmo_exp) warn_q <= 1'b1;
            if (fatal) err_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        phy_shutdown_n = 1'b0;
        phy_rst_n      = 1'b0;
        ctrl_rst_n     = 1'b0;
        freq_prog_req  = 1'b0;
        sensor_en      = 1'b0;
        link_up        = 1'b0;
        busy           = 1'b1;
        unique case (state_q)
            S_IDLE:        busy = 1'b0;
            S_FREQ:        freq_prog_req = 1'b1;
            S_LANES:       ;
            S_REL_SHUT:    phy_shutdown_n = 1'b1;
            S_REL_PHY: begin
                phy_shutdown_n = 1'b1;
                phy_rst_n      = 1'b1;
            end
            S_REL_CTRL, S_WAIT_STOP, S_DOWN_SENSOR: begin
                phy_shutdown_n = 1'b1;
                phy_rst_n      = 1'b1;
                ctrl_rst_n     = 1'b1;
            end
            S_SENSOR_ON, S_WAIT_CLK: begin
                phy_shutdown_n = 1'b1;
                phy_rst_n      = 1'b1;
                ctrl_rst_n     = 1'b1;
                sensor_en      = 1'b1;
            end
            S_UP: begin
                phy_shutdown_n = 1'b1;
                phy_rst_n      = 1'b1;
                ctrl_rst_n     = 1'b1;
                sensor_en      = 1'b1;
                link_up        = 1'b1;
                busy           = 1'b0;
            end
            S_DOWN_RESET:  ;
            default:       busy = 1'b0;
        endcase
    end

    assign lane_code = lane_q;
    assign freq_mbps = rate_q;
    assign stop_warn = warn_q;
    assign link_err  = err_q;

    // ---------------- assertions ----------------
    // R4: controller reset is never released ahead of the PHY controls
    p_ctrl_after_phy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_n |-> (phy_rst_n && phy_shutdown_n));

    // R4: PHY reset is never released while the PHY is shut down
    p_phy_after_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_n |-> phy_shutdown_n);

    // R2: the frequency strobe is a single cycle inside the reset phase
    p_freq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        freq_prog_req |=> !freq_prog_req);
    p_freq_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        freq_prog_req |-> !phy_shutdown_n);

    // R5: the sensor starts only after stop state or a stop-state timeout
    p_stop_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sensor_en) |-> ($past(stop_met) || stop_warn));

    // R7: the link is up only after the HS clock was seen, with the sensor on
    p_up_after_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(phy_state[CLK_HS_BIT]));
    p_up_needs_sensor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> sensor_en);

    // R10: resets assert only after the sensor has already stopped
    p_sensor_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rst_n) |-> !$past(sensor_en));

    // R8: all three resets assert in the same cycle
    p_resets_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rst_n) |-> (!phy_rst_n && !phy_shutdown_n));

    // R11: busy and streaming are exclusive
    p_busy_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !link_up);

endmodule

// File: tb/csi_bringup_seq_tb.sv
`timescale 1ns/1ps
module csi_bringup_seq_tb;
    localparam int TMO = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_lanes = 3'd1;
    logic        rate_valid = 1'b0;
    logic [11:0] rate_mbps = '0;
    logic        stream_on_req = 1'b0;
    logic        stream_off_req = 1'b0;
    logic [15:0] phy_state = '0;
    logic        sensor_ack = 1'b0;
    logic [1:0]  lane_code;
    logic        phy_shutdown_n, phy_rst_n, ctrl_rst_n, freq_prog_req;
    logic [11:0] freq_mbps;
    logic        sensor_en, link_up, stop_warn, link_err, busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    csi_bringup_seq #(.TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .rate_valid(rate_valid),
        .rate_mbps(rate_mbps), .stream_on_req(stream_on_req),
        .stream_off_req(stream_off_req), .phy_state(phy_state), .sensor_ack(sensor_ack),
        .lane_code(lane_code), .phy_shutdown_n(phy_shutdown_n), .phy_rst_n(phy_rst_n),
        .ctrl_rst_n(ctrl_rst_n), .freq_prog_req(freq_prog_req), .freq_mbps(freq_mbps),
        .sensor_en(sensor_en), .link_up(link_up), .stop_warn(stop_warn),
        .link_err(link_err), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int f_lanes(input int lanes);
        return (lanes < 1) ? 1 : ((lanes > 4) ? 4 : lanes);
    endfunction

    function automatic int f_code(input int lanes);
        return f_lanes(lanes) - 1;
    endfunction

    function automatic int f_rate(input bit rv, input logic [11:0] rate);
        return rv ? int'(rate) : 849;
    endfunction

    function automatic logic [15:0] f_mask(input int lanes);
        logic [15:0] m = 16'h0400;
        for (int i = 0; i < f_lanes(lanes); i++) m[4 + i] = 1'b1;
        return m;
    endfunction

    function automatic bit f_stop_ok(input int lanes, input logic [15:0] w);
        return (w & f_mask(lanes)) == f_mask(lanes);
    endfunction

    // Issue a start and check the fixed-order prefix; k counts cycles from the stop wait
    task automatic bring_up(input int lanes, input logic [15:0] w, input bit rv,
                            input logic [11:0] rate, input bit ack, output int k);
        cfg_lanes  = 3'(lanes);
        phy_state  = w;
        rate_valid = rv;
        rate_mbps  = rate;
        sensor_ack = ack;
        @(negedge clk) stream_on_req = 1'b1;
        @(negedge clk) stream_on_req = 1'b0;
        chk(freq_prog_req && !phy_shutdown_n && freq_mbps == 12'(f_rate(rv, rate)),
            "R2 freq strobe and rate", int'(freq_mbps), f_rate(rv, rate));
        @(negedge clk);
        chk(!freq_prog_req && !phy_shutdown_n && int'(lane_code) == f_code(lanes),
            "R3 lane code", int'(lane_code), f_code(lanes));
        @(negedge clk);
        chk(phy_shutdown_n && !phy_rst_n && !ctrl_rst_n, "R4 shutdown released first",
            int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n}), 4);
        @(negedge clk);
        chk(phy_shutdown_n && phy_rst_n && !ctrl_rst_n, "R4 phy reset second",
            int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n}), 6);
        @(negedge clk);
        chk(ctrl_rst_n && phy_rst_n && !sensor_en, "R4 controller reset third",
            int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n}), 7);
        @(negedge clk);
        k = 0;
        while (!link_up && !link_err && k < TMO + 40) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic tear_down();
        @(negedge clk) stream_off_req = 1'b1;
        @(negedge clk) stream_off_req = 1'b0;
        chk(!sensor_en && ctrl_rst_n && phy_rst_n && busy && !link_up,
            "R10 sensor drops first", int'({sensor_en, ctrl_rst_n}), 1);
        @(negedge clk);
        chk(!ctrl_rst_n && !phy_rst_n && !phy_shutdown_n, "R10 resets together",
            int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n}), 0);
        @(negedge clk);
        chk(!busy && !sensor_en, "R10 back to idle", int'(busy), 0);
    endtask

    // expect a clean bring-up through a met stop mask
    task automatic expect_fast_up(input int k, input string tag);
        chk(link_up && sensor_en && k == 3, tag, k, 3);
        chk(!stop_warn && !link_err, tag, int'({stop_warn, link_err}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!phy_shutdown_n && !phy_rst_n && !ctrl_rst_n && !sensor_en && !freq_prog_req
            && !link_up && !busy && lane_code == 2'd0, "R1 reset state",
            int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n, sensor_en, link_up, busy}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 R7: four lanes, stop mask met, default rate
        bring_up(4, 16'h05F0, 1'b0, 12'd0, 1'b1, k);
        expect_fast_up(k, "R5 R7 four-lane fast bring-up");
        tear_down();

        // R3: zero lanes clamps to one; only lane 0 stop bit matters
        bring_up(0, 16'h0510, 1'b1, 12'd400, 1'b1, k);
        expect_fast_up(k, "R3 R5 zero-lane clamp");
        tear_down();

        // R3: oversize lane count clamps to four
        bring_up(7, 16'h05F0, 1'b1, 12'd1500, 1'b1, k);
        expect_fast_up(k, "R3 oversize clamp");
        tear_down();

        // R6: two lanes, lane 1 never stops -> warning, bring-up continues
        bring_up(2, 16'h0510, 1'b1, 12'd600, 1'b1, k);
        chk(link_up && k == TMO + 2, "R6 stop timeout continues", k, TMO + 2);
        chk(stop_warn && !link_err, "R6 warning set", int'(stop_warn), 1);
        tear_down();

        // R8: HS clock never arrives -> fatal unwind
        bring_up(1, 16'h0410 | 16'h0010, 1'b0, 12'd0, 1'b1, k);
        chk(link_err && k == TMO + 2, "R8 clock timeout", k, TMO + 2);
        chk(!sensor_en && ctrl_rst_n && phy_rst_n && phy_shutdown_n,
            "R8 sensor dropped before resets", int'({sensor_en, ctrl_rst_n}), 1);
        @(negedge clk);
        chk(!ctrl_rst_n && !phy_rst_n && !phy_shutdown_n && link_err,
            "R8 resets assert together", int'({phy_shutdown_n, phy_rst_n, ctrl_rst_n}), 0);
        @(negedge clk);
        chk(!busy, "R8 idle after fatal", int'(busy), 0);
        // count was cleared: a single stream-on restarts
        bring_up(1, 16'h0510, 1'b0, 12'd0, 1'b1, k);
        expect_fast_up(k, "R8 restart after fatal clears error");
        tear_down();

        // R8: sensor never acknowledges
        bring_up(2, 16'h0530, 1'b0, 12'd0, 1'b0, k);
        chk(link_err && !sensor_en && k == TMO + 1, "R8 acknowledge timeout", k, TMO + 1);
        repeat (2) @(negedge clk);
        chk(!busy && !ctrl_rst_n, "R8 idle after ack timeout", int'(busy), 0);

        // R9: reference counting
        bring_up(3, 16'h0570, 1'b1, 12'd300, 1'b1, k);
        expect_fast_up(k, "R9 first user");
        @(negedge clk) stream_on_req = 1'b1;
        @(negedge clk) stream_on_req = 1'b0;
        begin
            bit ok = 1'b1;
            repeat (3) begin
                if (freq_prog_req || !link_up) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R9 second on does not restart", int'(link_up), 1);
        end
        @(negedge clk) stream_off_req = 1'b1;
        @(negedge clk) stream_off_req = 1'b0;
        begin
            bit ok = 1'b1;
            repeat (3) begin
                if (!link_up || !sensor_en) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R9 off at count two keeps streaming", int'(link_up), 1);
        end
        tear_down();
        @(negedge clk) stream_off_req = 1'b1;
        @(negedge clk) stream_off_req = 1'b0;
        begin
            bit ok = 1'b1;
            repeat (3) begin
                if (busy || phy_shutdown_n || freq_prog_req) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R9 off at zero ignored", int'(busy), 0);
        end
        bring_up(1, 16'h0510, 1'b0, 12'd0, 1'b1, k);
        expect_fast_up(k, "R9 count not negative");
        tear_down();

        // R11: request while busy is dropped
        cfg_lanes = 3'd1;
        phy_state = 16'h0510;
        sensor_ack = 1'b1;
        @(negedge clk) stream_on_req = 1'b1;
        @(negedge clk) stream_on_req = 1'b0;
        @(negedge clk) stream_on_req = 1'b1;
        chk(busy, "R11 busy during bring-up", int'(busy), 1);
        @(negedge clk) stream_on_req = 1'b0;
        k = 0;
        while (!link_up && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(link_up, "R11 bring-up completes", int'(link_up), 1);
        tear_down();

        // R12: simultaneous on and off cancel
        bring_up(2, 16'h0530, 1'b1, 12'd900, 1'b1, k);
        expect_fast_up(k, "R12 setup");
        @(negedge clk) begin stream_on_req = 1'b1; stream_off_req = 1'b1; end
        @(negedge clk) begin stream_on_req = 1'b0; stream_off_req = 1'b0; end
        begin
            bit ok = 1'b1;
            repeat (3) begin
                if (!link_up || !sensor_en) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R12 no change", int'(link_up), 1);
        end
        tear_down();

        // Random trials: R5 R6 with random words and lanes, R2 random rates
        for (int t = 0; t < 12; t++) begin
            int          ln = 1 + int'($urandom % 4);
            logic [15:0] w  = 16'($urandom);
            bit          rv = 1'($urandom);
            logic [11:0] rt = 12'($urandom);
            w[8] = 1'b1;
            if ($urandom % 2 == 0) w = w | f_mask(ln);
            bring_up(ln, w, rv, rt, 1'b1, k);
            if (f_stop_ok(ln, w)) begin
                chk(link_up && k == 3 && !stop_warn, "R5 random mask met", k, 3);
            end else begin
                chk(link_up && k == TMO + 2 && stop_warn, "R6 random mask unmet", k, TMO + 2);
            end
            tear_down();
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule